// File: doc/BRIEF.md
# Numeric Coprocessor Bus Interface

This block sits between a CPU and a numeric coprocessor. It decodes an eight-port I/O window into an active-low chip select for the coprocessor. It passes the coprocessor's busy signal through to the CPU. When the coprocessor flags an error while it is busy, the block holds the CPU busy line active and raises an interrupt. Both stay held until software writes to one of two clear ports.

One of the two clear ports also starts a fixed-length reset pulse to the coprocessor. System reset drives that same reset output. The busy and error inputs come from another timing domain, so each passes through a two-stage synchronizer before use. The asynchronous system reset is asserted at once and released in step with the clock.

Top module: `cpx_iface`

## Requirements
- R1: `cop_cs_n` is low in the same cycle that the 16-bit `io_addr` is in the range 0x00F8 to 0x00FF, and high for any other address, whether or not `io_wr` is set.
- R2: While no error is held, `cpu_busy_n` follows `cop_busy_n` (both active low) in both directions.
- R3: When the synchronized error (`cop_error_n` low) and the synchronized busy are both active on a clock edge, `cop_int` goes high and `cpu_busy_n` goes low from the following cycle. Both stay that way after the coprocessor releases busy and error.
- R4: An error reported while the coprocessor is not busy has no effect: `cop_int` stays low and `cpu_busy_n` stays high.
- R5: A cycle with `io_wr` high and `io_addr` equal to 0x00F0 or 0x00F1 clears the held error from the next cycle. A write to any other address, including 0x01F0, leaves it held.
- R6: If the error-while-busy condition is still present on the edge of a clear write, the hold is not released; setting wins over clearing.
- R7: While `rst_n` is low, `cop_int` is low, `cpu_busy_n` is high and `cop_reset` is high. `cop_reset` stays high for one more cycle after `rst_n` rises and is low from the second cycle.
- R8: A write to 0x00F1 drives `cop_reset` high for exactly 8 cycles, starting the cycle after the write. A further write to 0x00F1 during the pulse restarts the 8-cycle count. A write to 0x00F0 does not pulse the reset.
- R9: `cop_busy_n` and `cop_error_n` pass through two flip-flop stages. A change on either input affects the outputs no sooner than the second clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| io_addr | input | 16 | I/O address of the current bus cycle |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| cop_busy_n | input | 1 | Coprocessor busy, active low, asynchronous |
| cop_error_n | input | 1 | Coprocessor error, active low, asynchronous |
| cpu_busy_n | output | 1 | Busy to the CPU, active low |
| cop_int | output | 1 | Coprocessor error interrupt, active high |
| cop_cs_n | output | 1 | Coprocessor chip select, active low |
| cop_reset | output | 1 | Coprocessor reset, active high |

## Verification
The bench pushes a clear write against an error that is still present. A design that lets clearing win would drop the interrupt even though the fault remains. It writes to 0x00F2 and 0x01F0 to catch a clear decode that is too loose, and writes to 0x00F1 twice, four cycles apart, so that a pulse counter that ignores a retrigger ends early. It also samples one cycle after a busy change to expose a missing synchronizer stage, and asserts reset while an error is held to show that the hold is dropped at once rather than on the next edge.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  // Default port map of the coprocessor window
  localparam int unsigned CS_BASE_DEF  = 32'h00F8;
  localparam int unsigned CS_SPAN_LOG2 = 3;
  localparam int unsigned CLR_PORT_DEF = 32'h00F0;
  localparam int unsigned RST_PORT_DEF = 32'h00F1;

  // Synchronized coprocessor status, active high
  typedef struct packed {
    logic busy;
    logic err;
  } cpx_stat_t;
endpackage

// File: rtl/cpx_rst_sync.sv
module cpx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cpx_sync.sv
module cpx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      always_comb stg_d = d;
    end else begin : g_next
      always_comb stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= IDLE;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cpx_err_hold.sv
module cpx_err_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_act,
  input  logic err_act,
  input  logic clr,
  output logic held
);
  logic held_q;
  logic held_d;
  logic set_now;

  always_comb begin
    set_now = busy_act & err_act;
    held_d  = held_q;
    if (clr)     held_d = 1'b0;
    if (set_now) held_d = 1'b1;   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  assign held = held_q;
endmodule

// File: rtl/cpx_rst_pulse.sv
module cpx_rst_pulse #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | (cnt_q != '0);
    cnt_d  = start ? LOAD : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/cpx_iface.sv
module cpx_iface
  import cpx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned RST_CYC   = 8,
  parameter logic [ADDR_W-1:0] CS_BASE  = ADDR_W'(CS_BASE_DEF),
  parameter logic [ADDR_W-1:0] CLR_PORT = ADDR_W'(CLR_PORT_DEF),
  parameter logic [ADDR_W-1:0] RST_PORT = ADDR_W'(RST_PORT_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              cop_busy_n,
  input  logic              cop_error_n,
  output logic              cpu_busy_n,
  output logic              cop_int,
  output logic              cop_cs_n,
  output logic              cop_reset
);
  localparam logic [ADDR_W-1:0] CS_MASK = ~((ADDR_W'(1) << CS_SPAN_LOG2) - ADDR_W'(1));

  logic      rst_sync_n;
  logic [1:0] raw_n;
  logic [1:0] sync_n;
  cpx_stat_t stat;
  logic      clr_wr;
  logic      rst_wr;
  logic      held;
  logic      pulse_on;

  cpx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign raw_n = {cop_busy_n, cop_error_n};

  cpx_sync #(.W(2), .STAGES(SYNC_STG), .IDLE(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (raw_n),
    .q     (sync_n)
  );

  always_comb begin
    stat.busy = ~sync_n[1];
    stat.err  = ~sync_n[0];
    rst_wr    = io_wr & (io_addr == RST_PORT);
    clr_wr    = io_wr & ((io_addr == CLR_PORT) | (io_addr == RST_PORT));
  end

  cpx_err_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .busy_act (stat.busy),
    .err_act  (stat.err),
    .clr      (clr_wr),
    .held     (held)
  );

  cpx_rst_pulse #(.LEN(RST_CYC)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (rst_wr),
    .active (pulse_on)
  );

  assign cop_cs_n   = ~((io_addr & CS_MASK) == (CS_BASE & CS_MASK));
  assign cpu_busy_n = ~(stat.busy | held);
  assign cop_int    = held;
  assign cop_reset  = ~rst_sync_n | pulse_on;
endmodule

// File: rtl/cpx_iface_chk.sv
module cpx_iface_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned RST_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              cpu_busy_n,
  input logic              cop_int,
  input logic              cop_cs_n,
  input logic              cop_reset
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(248);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(255);

  logic          clr_wr;
  logic          f1_wr;
  logic [1:0]    since_rst;
  logic [CW-1:0] left_cnt;

  assign f1_wr  = io_wr && (io_addr == ADDR_W'(241));
  assign clr_wr = f1_wr || (io_wr && (io_addr == ADDR_W'(240)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      left_cnt  <= '0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      if (f1_wr)                left_cnt <= CW'(RST_CYC);
      else if (left_cnt != '0)  left_cnt <= left_cnt - CW'(1);
    end
  end

  AST_CS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cop_cs_n == !((io_addr >= LO) && (io_addr <= HI))); // R1

  AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_int && !clr_wr) |=> cop_int); // R3

  AST_INT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cop_int |-> !cpu_busy_n); // R3

  AST_RST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    f1_wr |=> cop_reset); // R8

  AST_RST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && left_cnt == '0) |-> !cop_reset); // R8
endmodule

bind cpx_iface cpx_iface_chk #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .cpu_busy_n (cpu_busy_n),
  .cop_int    (cop_int),
  .cop_cs_n   (cop_cs_n),
  .cop_reset  (cop_reset)
);

// File: tb/tb_cpx_iface.sv
`timescale 1ns/1ps
module tb_cpx_iface;
  localparam int SIG_BUSY = 0, SIG_INT = 1, SIG_RST = 2, SIG_CS = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        cop_busy_n;
  logic        cop_error_n;
  logic        cpu_busy_n;
  logic        cop_int;
  logic        cop_cs_n;
  logic        cop_reset;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int    due;
    int    sig;
    bit    val;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpx_iface dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .cop_busy_n(cop_busy_n), .cop_error_n(cop_error_n),
    .cpu_busy_n(cpu_busy_n), .cop_int(cop_int),
    .cop_cs_n(cop_cs_n), .cop_reset(cop_reset)
  );

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_at(input int dly, input int sig, input bit val, input string req);
    exp_t e;
    e.due = cyc + dly; e.sig = sig; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compares due items at the falling edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due <= cyc) begin
        logic act;
        case (sb[i].sig)
          SIG_BUSY: act = cpu_busy_n;
          SIG_INT:  act = cop_int;
          SIG_RST:  act = cop_reset;
          default:  act = cop_cs_n;
        endcase
        n_cmp++;
        if (act !== sb[i].val || sb[i].due != cyc) begin
          n_bad++;
          $display("FAIL %s sig=%0d cycle=%0d actual=%b expected=%b",
                   sb[i].req, sb[i].sig, cyc, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic latch_error();
    cop_busy_n = 1'b0; step(3);
    cop_error_n = 1'b0; step(4);
    cop_error_n = 1'b1; cop_busy_n = 1'b1; step(4);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0;
    cop_busy_n = 1'b1; cop_error_n = 1'b1;
    step(3);
    // R7 reset state
    expect_at(0, SIG_RST, 1'b1, "R7");
    expect_at(0, SIG_INT, 1'b0, "R7");
    expect_at(0, SIG_BUSY, 1'b1, "R7");
    step(1);
    rst_n = 1'b1;
    step(1);
    expect_at(0, SIG_RST, 1'b1, "R7");
    expect_at(1, SIG_RST, 1'b0, "R7");
    step(4);

    // R1 chip select window
    io_addr = 16'h00F8; expect_at(0, SIG_CS, 1'b0, "R1"); step(1);
    io_addr = 16'h00FF; expect_at(0, SIG_CS, 1'b0, "R1"); step(1);
    io_addr = 16'h00F7; expect_at(0, SIG_CS, 1'b1, "R1"); step(1);
    io_addr = 16'h01F8; expect_at(0, SIG_CS, 1'b1, "R1"); step(1);
    io_addr = 16'h0100; expect_at(0, SIG_CS, 1'b1, "R1"); step(1);

    // R2 / R9 pass-through with two-stage delay
    cop_busy_n = 1'b0;
    expect_at(1, SIG_BUSY, 1'b1, "R9");
    expect_at(2, SIG_BUSY, 1'b0, "R2");
    step(4);
    cop_busy_n = 1'b1;
    expect_at(1, SIG_BUSY, 1'b0, "R9");
    expect_at(2, SIG_BUSY, 1'b1, "R2");
    step(4);

    // R4 error while idle is ignored
    cop_error_n = 1'b0;
    expect_at(4, SIG_INT, 1'b0, "R4");
    expect_at(4, SIG_BUSY, 1'b1, "R4");
    step(5);
    cop_error_n = 1'b1; step(3);

    // R3 error during busy latches
    cop_busy_n = 1'b0; step(3);
    cop_error_n = 1'b0;
    expect_at(2, SIG_INT, 1'b0, "R9");
    expect_at(3, SIG_INT, 1'b1, "R3");
    step(1); cop_error_n = 1'b1;
    step(1); cop_busy_n = 1'b1;
    step(5);
    expect_at(0, SIG_INT, 1'b1, "R3");
    expect_at(0, SIG_BUSY, 1'b0, "R3");
    step(1);

    // R5 writes elsewhere keep the hold
    io_addr = 16'h00F2; io_wr = 1'b1;
    expect_at(1, SIG_INT, 1'b1, "R5"); step(1); io_wr = 1'b0; step(1);
    io_addr = 16'h01F0; io_wr = 1'b1;
    expect_at(1, SIG_INT, 1'b1, "R5"); step(1); io_wr = 1'b0; step(1);
    // clear through 0x00F0, no reset pulse
    io_addr = 16'h00F0; io_wr = 1'b1;
    expect_at(1, SIG_INT, 1'b0, "R5");
    expect_at(1, SIG_BUSY, 1'b1, "R5");
    expect_at(1, SIG_RST, 1'b0, "R8");
    step(1); io_wr = 1'b0; step(2);

    // R5 / R8 clear and reset through 0x00F1
    latch_error();
    io_addr = 16'h00F1; io_wr = 1'b1;
    expect_at(1, SIG_INT, 1'b0, "R5");
    expect_at(1, SIG_RST, 1'b1, "R8");
    expect_at(8, SIG_RST, 1'b1, "R8");
    expect_at(9, SIG_RST, 1'b0, "R8");
    step(1); io_wr = 1'b0; step(10);

    // R6 set beats clear
    cop_busy_n = 1'b0; step(3);
    cop_error_n = 1'b0; step(4);
    io_addr = 16'h00F0; io_wr = 1'b1;
    expect_at(1, SIG_INT, 1'b1, "R6");
    expect_at(2, SIG_INT, 1'b1, "R6");
    step(1); io_wr = 1'b0; step(2);
    cop_error_n = 1'b1; step(3);
    io_wr = 1'b1;
    expect_at(1, SIG_INT, 1'b0, "R6");
    expect_at(1, SIG_BUSY, 1'b0, "R2");
    step(1); io_wr = 1'b0; cop_busy_n = 1'b1; step(3);
    expect_at(0, SIG_BUSY, 1'b1, "R2");
    step(1);

    // R8 retrigger restarts the count
    io_addr = 16'h00F1; io_wr = 1'b1;
    expect_at(5, SIG_RST, 1'b1, "R8");
    step(1); io_wr = 1'b0; step(3);
    io_wr = 1'b1;
    expect_at(8, SIG_RST, 1'b1, "R8");
    expect_at(9, SIG_RST, 1'b0, "R8");
    step(1); io_wr = 1'b0; step(10);

    // R7 asynchronous reset drops a held error
    latch_error();
    rst_n = 1'b0; #0.5;
    expect_at(0, SIG_INT, 1'b0, "R7");
    expect_at(0, SIG_RST, 1'b1, "R7");
    expect_at(0, SIG_BUSY, 1'b1, "R7");
    step(2);
    rst_n = 1'b1;
    step(1);
    expect_at(0, SIG_RST, 1'b1, "R7");
    expect_at(1, SIG_RST, 1'b0, "R7");
    step(4);

    if (sb.size() != 0) begin
      n_bad += sb.size();
      $display("FAIL scoreboard left %0d unchecked items", sb.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule